// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for a synchronous memory that serves four data beats per address. A load command takes an external address and starts a burst. Each advance command moves to the next beat by changing only the two least significant address bits. The other address bits stay fixed for the whole burst.

A static mode input picks the beat order. Linear order counts the low bits up and wraps from 3 to 0. Interleaved order XORs the loaded low bits with the beat number. A clock-enable-style stall input freezes every register.

The control is a two-state machine, `ST_IDLE` and `ST_RUN`, with these named transitions:
- `START`: `ST_IDLE` to `ST_RUN` on a load while the chip is selected.
- `RESTART`: `ST_RUN` to `ST_RUN` on a load while the chip is selected. The beat count clears.
- `STEP`: `ST_RUN` to `ST_RUN` on an advance. The beat count goes up by one modulo 4.
- `END`: `ST_RUN` to `ST_IDLE` on a load while the chip is deselected.
- `HOLD`: no change while `stall` is high, or on an advance or a deselect in `ST_IDLE`.

Top module: `burst_seq`

## Requirements
- R1: After reset `burst_on` is 0 and `cur_addr` is all zeros.
- R2: On a clock edge with `stall`=0, `adv_ld`=0 and `sel_ok`=1, `cur_addr` equals `ext_addr` from that edge and `burst_on` is 1. A load that arrives during a burst restarts the burst at beat 0.
- R3: On a clock edge with `stall`=0, `adv_ld`=0 and `sel_ok`=0, `burst_on` goes to 0 and `cur_addr` keeps its value.
- R4: On a clock edge with `stall`=0 and `adv_ld`=1, `ext_addr` is ignored and bits `ADDR_W-1:2` of `cur_addr` do not change.
- R5: With `mode_ilv`=0 (linear order), each advance during a burst adds 1 modulo 4 to `cur_addr[1:0]`.
- R6: With `mode_ilv`=1 (interleaved order), beat k for k = 0..3 puts the loaded low two bits XOR k on `cur_addr[1:0]`.
- R7: An advance after the fourth beat wraps back to the first beat address, and `burst_on` stays 1.
- R8: An advance while no burst is active leaves `cur_addr` unchanged and keeps `burst_on` at 0.
- R9: On a clock edge with `stall`=1, `cur_addr`, `burst_on` and the beat position all keep their values, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | High freezes all state |
| adv_ld | input | 1 | 1 = advance the beat, 0 = load or deselect |
| sel_ok | input | 1 | Chip selected, meaningful when `adv_ld`=0 |
| mode_ilv | input | 1 | Static order select: 1 = interleaved, 0 = linear |
| ext_addr | input | ADDR_W | External address, captured on a load |
| cur_addr | output | ADDR_W | Current beat address |
| burst_on | output | 1 | A burst is active |

## Verification
Two pairs of functions can fall in the same cycle:
- A stall can coincide with a load or a deselect command. The stall must win, so `cur_addr` and `burst_on` stay frozen.
- A load can arrive while a burst is mid-way. The address must be replaced and the beat order must restart from the new low bits.

Both cases are provoked by directed sequences in each mode, followed by a long pseudo-random command stream. A behavioural model with an integer beat count judges every cycle, and the two orders are compared over wrap-around.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/burst_fsm.sv
module burst_fsm
    import burst_seq_pkg::*;
#(
    parameter int BEAT_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stall,
    input  logic                 adv_ld,
    input  logic                 sel_ok,
    output logic                 load_en,
    output logic                 burst_on,
    output logic [BEAT_BITS-1:0] beat
);
    seq_state_t state_q, state_d;
    logic [BEAT_BITS-1:0] beat_q, beat_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    // Next state and beat
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        if (!stall) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!adv_ld && sel_ok) begin         // START
                        state_d = ST_RUN;
                        beat_d  = '0;
                    end
                end
                ST_RUN: begin
                    if (adv_ld) begin                    // STEP
                        beat_d = beat_q + 1'b1;
                    end else if (sel_ok) begin           // RESTART
                        beat_d = '0;
                    end else begin                       // END
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        load_en  = !stall && !adv_ld && sel_ok;
        burst_on = (state_q == ST_RUN);
        beat     = beat_q;
    end

    // R9: a stalled edge keeps the beat position
    assert_stall_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (beat_q == $past(beat_q) && state_q == $past(state_q)));

    // R7: the beat position wraps from the last beat back to 0
    assert_beat_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && adv_ld && state_q == ST_RUN && beat_q == '1) |=> (beat_q == '0));
endmodule

// File: rtl/beat_addr.sv
module beat_addr #(
    parameter int ADDR_W    = 18,
    parameter int BEAT_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic                 mode_ilv,
    input  logic [ADDR_W-1:0]    ext_addr,
    input  logic [BEAT_BITS-1:0] beat,
    output logic [ADDR_W-1:0]    cur_addr
);
    logic [ADDR_W-1:0]    base_q;
    logic [BEAT_BITS-1:0] low_lin, low_ilv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (load_en) begin
            base_q <= ext_addr;
        end
    end

    always_comb begin
        low_lin  = base_q[BEAT_BITS-1:0] + beat;
        low_ilv  = base_q[BEAT_BITS-1:0] ^ beat;
        cur_addr = {base_q[ADDR_W-1:BEAT_BITS], (mode_ilv ? low_ilv : low_lin)};
    end

    // R6: in interleaved order, beat 0 shows the loaded low bits unchanged
    assert_ilv_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ilv && beat == '0) |-> (cur_addr == base_q));
endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              adv_ld,
    input  logic              sel_ok,
    input  logic              mode_ilv,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              burst_on
);
    localparam int BEAT_BITS = 2;

    logic                 load_en;
    logic [BEAT_BITS-1:0] beat;

    burst_fsm #(.BEAT_BITS(BEAT_BITS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall    (stall),
        .adv_ld   (adv_ld),
        .sel_ok   (sel_ok),
        .load_en  (load_en),
        .burst_on (burst_on),
        .beat     (beat)
    );

    beat_addr #(.ADDR_W(ADDR_W), .BEAT_BITS(BEAT_BITS)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .mode_ilv (mode_ilv),
        .ext_addr (ext_addr),
        .beat     (beat),
        .cur_addr (cur_addr)
    );

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !adv_ld && sel_ok) |=> (burst_on && cur_addr == $past(ext_addr)));

    assert_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !adv_ld && !sel_ok) |=> (!burst_on && $stable(cur_addr)));

    assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && adv_ld) |=> (cur_addr[ADDR_W-1:BEAT_BITS] == $past(cur_addr[ADDR_W-1:BEAT_BITS])));

    assert_linear_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && adv_ld && burst_on && !mode_ilv) |=>
        (cur_addr[BEAT_BITS-1:0] == $past(cur_addr[BEAT_BITS-1:0]) + 2'd1));

    assert_idle_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && adv_ld && !burst_on) |=> (!burst_on && $stable(cur_addr)));

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(cur_addr) && $stable(burst_on)));
endmodule

// File: tb/sim_burst_seq.sv
module sim_burst_seq;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall = 1'b0, adv_ld = 1'b1, sel_ok = 1'b0, mode_ilv = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] cur_addr;
    logic          burst_on;

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model state
    logic [AW-1:0] m_base;
    int            m_k;
    bit            m_on;

    always #10 clk = ~clk;

    burst_seq #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .stall(stall), .adv_ld(adv_ld),
        .sel_ok(sel_ok), .mode_ilv(mode_ilv), .ext_addr(ext_addr),
        .cur_addr(cur_addr), .burst_on(burst_on)
    );

    function automatic logic [AW-1:0] exp_addr();
        int lo;
        lo = mode_ilv ? (int'(m_base[1:0]) ^ m_k) : ((int'(m_base[1:0]) + m_k) % 4);
        return {m_base[AW-1:2], 2'(lo)};
    endfunction

    task automatic compare(string tag);
        logic [AW-1:0] ea;
        ea = exp_addr();
        checks++;
        if (cur_addr !== ea || burst_on !== m_on) begin
            fails++;
            $display("FAIL %s: addr=%h on=%0b expected addr=%h on=%0b",
                     tag, cur_addr, burst_on, ea, m_on);
        end
    endtask

    // one cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic step(bit st, bit adv, bit sel, logic [AW-1:0] a);
        string tag;
        stall = st; adv_ld = adv; sel_ok = sel; ext_addr = a;
        if (st)                    tag = "R9 stall";
        else if (!adv && sel)      tag = "R2 load";
        else if (!adv)             tag = "R3 deselect";
        else if (!m_on)            tag = "R8 idle advance";
        else if (m_k == 3)         tag = "R7 wrap";
        else if (mode_ilv)         tag = "R6 interleaved/R4";
        else                       tag = "R5 linear/R4";
        @(posedge clk);
        if (!st) begin
            if (!adv && sel) begin
                m_base = a; m_k = 0; m_on = 1;
            end else if (!adv) begin
                m_on = 0;
            end else if (m_on) begin
                m_k = (m_k + 1) % 4;
            end
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset(bit md);
        rst_n = 1'b0; mode_ilv = md;
        stall = 0; adv_ld = 1; sel_ok = 0; ext_addr = '0;
        m_base = '0; m_k = 0; m_on = 0;
        @(negedge clk); @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        for (int md = 0; md < 2; md++) begin
            do_reset(md[0]);
            step(0, 1, 1, 18'h2AAAA);          // R8 advance while idle
            step(0, 0, 1, 18'h12345);          // R2 load, low bits 01
            for (int i = 0; i < 5; i++)
                step(0, 1, 0, 18'h3FFFF);      // R4/R5/R6/R7 beats and wrap
            step(1, 0, 1, 18'h00F0F);          // R9 stall beats load
            step(1, 0, 0, 18'h00F0F);          // R9 stall beats deselect
            step(0, 1, 1, 18'h00000);
            step(0, 0, 1, 18'h0ABC3);          // R2 load, low bits 11
            step(0, 1, 1, 18'h11111);
            step(0, 1, 1, 18'h11111);
            step(0, 0, 1, 18'h3FFF2);          // R2 restart mid-burst
            for (int i = 0; i < 4; i++)
                step(0, 1, 1, 18'h00001);
            step(0, 0, 0, 18'h12121);          // R3 end burst
            step(0, 1, 1, 18'h05555);          // R8 advance after end
            step(0, 1, 0, 18'h05555);
            for (int i = 0; i < 120; i++) begin
                logic [3:0] r;
                r = 4'($urandom);
                step(r[0] & r[1], r[2] | r[3], r[1] | r[3], AW'($urandom));
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule